// File: doc/BRIEF.md
# Flash Toggle-Bit Status Generator

This block produces the status byte that a parallel NOR flash returns on its data bus while an embedded program or erase operation runs. It keeps two separate toggle flip-flops. The device-level toggle, on bit 6, inverts at the close of every read while the algorithm is running. It holds steady when the device is idle or erase-suspended. The sector-level toggle, on bit 2, inverts only when the read lands in a sector that is marked for erase. It keeps inverting while the erase is suspended, so software can combine the two bits to learn both the mode and the sectors involved.

An abstract controller supplies the operation state: a running flag, a suspended flag, the per-sector erase mask, and a one-cycle pulse when the last command write is accepted. That pulse also says whether the command was an erase and whether every sector it targets is protected. A command that targets only protected sectors does no work. Instead, a cycle counter keeps the device-level toggle active for a fixed window, about 100 µs for an erase and about 2 µs for a program, and the array is then readable again. The remaining status bits pass through from an input port. Both outputs are registered.

Top module: `flash_toggle_status`

## Requirements
- R1: A read cycle ends at the first clock where the two active-low strobes `oe_n` and `ce_n` are not both low, after a clock where both were low. If `op_busy` is 1 at that clock, bit 6 of the toggle state inverts, whatever the read sector.
- R2: Either strobe alone can close the read: raising only `oe_n` while `ce_n` stays low ends the cycle, and so does raising only `ce_n`.
- R3: Bit 6 of the toggle state keeps its value at every clock where `op_busy` is 0 and no protection window is open. This includes erase suspend.
- R4: When a read ends, bit 2 of the toggle state inverts if `erase_sel[s]` is 1 and `op_busy` or `erase_susp` is 1. Here `s` is the value of `rd_sector` at the last clock of the read.
- R5: Bit 2 of the toggle state is unchanged by reads to sectors whose `erase_sel` bit is 0, and by any read while both `op_busy` and `erase_susp` are 0.
- R6: A `cmd_done` pulse with `cmd_erase`=1 and `cmd_all_prot`=1 opens a window of CLK_MHZ*ERASE_PROT_US clocks. During the window, reads invert bit 6 as if the device were busy.
- R7: A `cmd_done` pulse with `cmd_erase`=0 and `cmd_all_prot`=1 opens a window of CLK_MHZ*PROG_PROT_US clocks, with the same effect on bit 6.
- R8: A `cmd_done` pulse with `cmd_all_prot`=0 closes any open window. Partly protected commands therefore toggle only by `op_busy`.
- R9: `status_out` is updated one clock after its sources. Bits 7,5,4,3,1,0 come from `pass_bits[5:0]` in that order, and bits 6 and 2 are the toggle flip-flops.
- R10: `array_rd_en` is 1 one clock after a clock where `op_busy`, `erase_susp`, `cmd_done` and the window are all inactive, and 0 otherwise.
- R11: Synchronous reset `rst` clears both toggle bits, the window, `status_out` and `array_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 1 | Output-enable read strobe, active low |
| ce_n | input | 1 | Chip-enable read strobe, active low |
| rd_sector | input | SECT_W | Sector of the current read address |
| cmd_done | input | 1 | Final command write accepted (one-clock pulse) |
| cmd_erase | input | 1 | With cmd_done: 1 = erase, 0 = program |
| cmd_all_prot | input | 1 | With cmd_done: every target sector is protected |
| op_busy | input | 1 | Embedded algorithm executing |
| erase_susp | input | 1 | Erase suspended |
| erase_sel | input | SECTORS | Per-sector erase selection mask |
| pass_bits | input | 6 | Status bits 7,5,4,3,1,0 supplied externally |
| status_out | output | 8 | Registered status byte |
| array_rd_en | output | 1 | Registered array-read permission |

## Verification
The bench builds the block with CLK_MHZ=1, ERASE_PROT_US=20 and PROG_PROT_US=3. This makes the protection windows 20 and 3 clocks long, so a run of reads can cross the end of each window and show exactly when bit 6 stops moving and `array_rd_en` returns. It uses eight sectors with a mixed erase mask, so reads both inside and outside the selection occur in running, suspended and suspend-program states. A window is also cut short by a later command that is only partly protected.

// File: rtl/ftog_pkg.sv
package ftog_pkg;

  function automatic int unsigned win_cycles(input int unsigned mhz, input int unsigned us);
    return (mhz * us < 1) ? 1 : mhz * us;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  typedef struct packed {
    logic adv_dev;
    logic adv_sec;
  } tog_adv_t;

endpackage

// File: rtl/ftog_strobe.sv
module ftog_strobe #(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic              ce_n,
  input  logic [SECT_W-1:0] sector,
  output logic              rd_end,
  output logic [SECT_W-1:0] sect_q
);
  logic rd_now;
  logic rd_q;

  assign rd_now = ~oe_n & ~ce_n;
  assign rd_end = rd_q & ~rd_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      sect_q <= '0;
    end else begin
      rd_q <= rd_now;
      if (rd_now) sect_q <= sector;
    end
  end
endmodule

// File: rtl/ftog_window.sv
module ftog_window
  import ftog_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 100,
  parameter int unsigned PROG_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_done,
  input  logic cmd_erase,
  input  logic cmd_all_prot,
  output logic win_act
);
  localparam int unsigned MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CW   = cnt_width(MAXC);
  localparam logic [CW-1:0] E_LOAD = CW'(ERASE_CYC);
  localparam logic [CW-1:0] P_LOAD = CW'(PROG_CYC);

  logic [CW-1:0] cnt;

  assign win_act = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cmd_done) begin
      if (cmd_all_prot) cnt <= cmd_erase ? E_LOAD : P_LOAD;
      else              cnt <= '0;
    end else if (win_act) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ftog_bit.sv
module ftog_bit (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
  import ftog_pkg::*;
#(
  parameter int unsigned SECTORS       = 8,
  parameter int unsigned CLK_MHZ       = 100,
  parameter int unsigned ERASE_PROT_US = 100,
  parameter int unsigned PROG_PROT_US  = 2,
  parameter int unsigned SECT_W        = (SECTORS < 2) ? 1 : $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oe_n,
  input  logic               ce_n,
  input  logic [SECT_W-1:0]  rd_sector,
  input  logic               cmd_done,
  input  logic               cmd_erase,
  input  logic               cmd_all_prot,
  input  logic               op_busy,
  input  logic               erase_susp,
  input  logic [SECTORS-1:0] erase_sel,
  input  logic [5:0]         pass_bits,
  output logic [7:0]         status_out,
  output logic               array_rd_en
);
  localparam int unsigned ERASE_CYC = win_cycles(CLK_MHZ, ERASE_PROT_US);
  localparam int unsigned PROG_CYC  = win_cycles(CLK_MHZ, PROG_PROT_US);

  logic              rd_end;
  logic [SECT_W-1:0] sect_q;
  logic              win_act;
  logic              sel_hit;
  logic              t6_q;
  logic              t2_q;
  tog_adv_t          adv;

  ftog_strobe #(.SECT_W(SECT_W)) u_strobe (
    .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n),
    .sector(rd_sector), .rd_end(rd_end), .sect_q(sect_q)
  );

  ftog_window #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_window (
    .clk(clk), .rst(rst), .cmd_done(cmd_done), .cmd_erase(cmd_erase),
    .cmd_all_prot(cmd_all_prot), .win_act(win_act)
  );

  // sector lookup: guard indices beyond the mask when SECTORS is not a power of two
  always_comb begin
    sel_hit = 1'b0;
    for (int i = 0; i < SECTORS; i++) begin
      if (sect_q == SECT_W'(i)) sel_hit = erase_sel[i];
    end
  end

  assign adv.adv_dev = rd_end & (op_busy | win_act);
  assign adv.adv_sec = rd_end & (op_busy | erase_susp) & sel_hit;

  ftog_bit u_dev_bit (.clk(clk), .rst(rst), .adv(adv.adv_dev), .q(t6_q));
  ftog_bit u_sec_bit (.clk(clk), .rst(rst), .adv(adv.adv_sec), .q(t2_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_out  <= '0;
      array_rd_en <= 1'b0;
    end else begin
      status_out  <= {pass_bits[5], t6_q, pass_bits[4:2], t2_q, pass_bits[1:0]};
      array_rd_en <= ~(op_busy | erase_susp | win_act | cmd_done);
    end
  end
endmodule

// File: rtl/ftog_checker.sv
module ftog_checker #(
  parameter int unsigned SECTORS = 8,
  parameter int unsigned SECT_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               oe_n,
  input logic               ce_n,
  input logic               cmd_done,
  input logic               cmd_erase,
  input logic               cmd_all_prot,
  input logic               op_busy,
  input logic               erase_susp,
  input logic [SECTORS-1:0] erase_sel,
  input logic [5:0]         pass_bits,
  input logic [SECT_W-1:0]  sect_q,
  input logic               win_act,
  input logic               t6_q,
  input logic               t2_q,
  input logic [7:0]         status_out,
  input logic               array_rd_en
);
  logic was_rd;
  logic rd_close;
  logic sel_now;

  always_ff @(posedge clk) begin
    if (rst) was_rd <= 1'b0;
    else     was_rd <= ~oe_n & ~ce_n;
  end
  assign rd_close = was_rd & ~(~oe_n & ~ce_n);
  assign sel_now  = (32'(sect_q) < SECTORS) ? erase_sel[sect_q] : 1'b0;

  AST_DEV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (rd_close && op_busy) |=> (t6_q != $past(t6_q))); // R1
  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_busy && !win_act) |=> $stable(t6_q)); // R3
  AST_SEC_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (rd_close && sel_now && (op_busy || erase_susp)) |=> (t2_q != $past(t2_q))); // R4
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_close || !sel_now) |=> $stable(t2_q)); // R5
  AST_WIN_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && cmd_all_prot) |=> win_act); // R6
  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !cmd_all_prot) |=> !win_act); // R8
  AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_out[7] == $past(pass_bits[5]) && status_out[0] == $past(pass_bits[0]))); // R9
  AST_ARRAY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (op_busy || erase_susp) |=> !array_rd_en); // R10
endmodule

bind flash_toggle_status ftog_checker #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_ftog_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n), .cmd_done(cmd_done),
  .cmd_erase(cmd_erase), .cmd_all_prot(cmd_all_prot), .op_busy(op_busy),
  .erase_susp(erase_susp), .erase_sel(erase_sel), .pass_bits(pass_bits),
  .sect_q(sect_q), .win_act(win_act), .t6_q(t6_q), .t2_q(t2_q),
  .status_out(status_out), .array_rd_en(array_rd_en)
);

// File: tb/test_flash_toggle_status.sv
`timescale 1ns/1ps
module test_flash_toggle_status;
  localparam int SECTORS = 8;
  localparam int SECT_W  = 3;
  localparam int MHZ     = 1;
  localparam int E_US    = 20;
  localparam int P_US    = 3;
  localparam int E_CYC   = MHZ * E_US;
  localparam int P_CYC   = MHZ * P_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b1, ce_n = 1'b1;
  logic [SECT_W-1:0] rd_sector = '0;
  logic cmd_done = 1'b0, cmd_erase = 1'b0, cmd_all_prot = 1'b0;
  logic op_busy = 1'b0, erase_susp = 1'b0;
  logic [SECTORS-1:0] erase_sel = '0;
  logic [5:0] pass_bits = '0;
  logic [7:0] status_out;
  logic array_rd_en;

  int checks = 0;
  int errors = 0;
  string tag = "R11";

  always #2 clk = ~clk;

  flash_toggle_status #(
    .SECTORS(SECTORS), .CLK_MHZ(MHZ), .ERASE_PROT_US(E_US), .PROG_PROT_US(P_US)
  ) i_flash_toggle_status (
    .clk(clk), .rst(rst), .oe_n(oe_n), .ce_n(ce_n), .rd_sector(rd_sector),
    .cmd_done(cmd_done), .cmd_erase(cmd_erase), .cmd_all_prot(cmd_all_prot),
    .op_busy(op_busy), .erase_susp(erase_susp), .erase_sel(erase_sel),
    .pass_bits(pass_bits), .status_out(status_out), .array_rd_en(array_rd_en)
  );

  // behavioural reference model
  bit m_rdprev, m_t6, m_t2, m_arr;
  int m_sect, m_cnt;
  logic [7:0] m_status;

  always @(posedge clk) begin
    bit rd_now, rd_end, win;
    rd_now = (oe_n == 1'b0) && (ce_n == 1'b0);
    if (rst) begin
      m_rdprev = 0; m_t6 = 0; m_t2 = 0; m_arr = 0; m_sect = 0; m_cnt = 0; m_status = 8'h00;
    end else begin
      rd_end = m_rdprev && !rd_now;
      win = (m_cnt > 0);
      m_status = {pass_bits[5], m_t6, pass_bits[4], pass_bits[3], pass_bits[2], m_t2, pass_bits[1], pass_bits[0]};
      m_arr = !(op_busy || erase_susp || win || cmd_done);
      if (rd_end && (op_busy || win)) m_t6 = !m_t6;
      if (rd_end && (op_busy || erase_susp) && erase_sel[m_sect]) m_t2 = !m_t2;
      if (cmd_done) m_cnt = cmd_all_prot ? (cmd_erase ? E_CYC : P_CYC) : 0;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (rd_now) m_sect = int'(rd_sector);
      m_rdprev = rd_now;
    end
  end

  // per-clock comparison, away from the edge
  always @(posedge clk) begin
    #1;
    checks++;
    if (status_out !== m_status || array_rd_en !== m_arr) begin
      errors++;
      $display("FAIL %s: status_out=%h array_rd_en=%b expected status_out=%h array_rd_en=%b",
               tag, status_out, array_rd_en, m_status, m_arr);
    end
  end

  task automatic do_read(input int sec, input bit via_oe);
    @(negedge clk);
    rd_sector = SECT_W'(sec);
    pass_bits = 6'(sec * 11 + 5);
    oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (via_oe) oe_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic pulse_cmd(input bit erase, input bit allp);
    @(negedge clk);
    cmd_done = 1'b1; cmd_erase = erase; cmd_all_prot = allp;
    @(negedge clk);
    cmd_done = 1'b0; cmd_all_prot = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic direct(input string t, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", t, got, exp);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit s6;
    tag = "R11";
    idle(3);
    direct("R11 status after reset", status_out == 8'h00, 1'b1);
    direct("R11 array_rd_en after reset", array_rd_en, 1'b0);
    rst = 1'b0;

    tag = "R3 idle";
    do_read(1, 1); do_read(4, 0);
    idle(2);
    direct("R10 idle array enable", array_rd_en, 1'b1);
    direct("R3 bit6 idle", status_out[6], 1'b0);

    tag = "R1 R2 program busy";
    pulse_cmd(1'b0, 1'b0);
    op_busy = 1'b1;
    do_read(0, 1);
    idle(2);
    direct("R1 bit6 after one read", status_out[6], 1'b1);
    do_read(7, 0);
    idle(2);
    direct("R2 close by ce_n", status_out[6], 1'b0);
    do_read(3, 1); do_read(5, 0);
    op_busy = 1'b0;
    idle(3);

    tag = "R4 R5 erase busy";
    erase_sel = 8'b0010_0110;
    pulse_cmd(1'b1, 1'b0);
    op_busy = 1'b1;
    do_read(1, 1);
    idle(2);
    direct("R4 bit2 selected sector", status_out[2], 1'b1);
    do_read(0, 1);
    idle(2);
    direct("R5 bit2 unselected sector", status_out[2], 1'b1);
    do_read(5, 0); do_read(7, 1); do_read(2, 0);

    tag = "R3 R4 suspended";
    op_busy = 1'b0; erase_susp = 1'b1;
    idle(2);
    s6 = status_out[6];
    do_read(2, 1); do_read(6, 0); do_read(5, 1);
    idle(2);
    direct("R3 bit6 frozen in suspend", status_out[6], s6);

    tag = "R1 suspend-program";
    op_busy = 1'b1;
    do_read(3, 1); do_read(1, 0);
    op_busy = 1'b0;
    do_read(1, 1);
    erase_susp = 1'b0;
    tag = "R5 no operation";
    do_read(1, 1); do_read(2, 0);
    erase_sel = '0;
    idle(3);

    tag = "R6 protected erase window";
    pulse_cmd(1'b1, 1'b1);
    for (int k = 0; k < 8; k++) do_read(k, k[0]);
    idle(4);
    direct("R10 array enable after erase window", array_rd_en, 1'b1);

    tag = "R7 protected program window";
    pulse_cmd(1'b0, 1'b1);
    do_read(4, 1); do_read(6, 0); do_read(2, 1);
    idle(3);

    tag = "R8 partial protection clears window";
    pulse_cmd(1'b1, 1'b1);
    do_read(3, 1);
    pulse_cmd(1'b1, 1'b0);
    idle(1);
    direct("R8 array enable returns", array_rd_en, 1'b1);
    s6 = status_out[6];
    do_read(0, 1); do_read(5, 0);
    idle(2);
    direct("R8 bit6 steady after clear", status_out[6], s6);

    tag = "R11 mid-run reset";
    op_busy = 1'b1;
    do_read(1, 1);
    @(negedge clk); rst = 1'b1;
    idle(2);
    direct("R11 status cleared", status_out == 8'h00, 1'b1);
    op_busy = 1'b0; rst = 1'b0;
    tag = "R9 pass-through";
    do_read(6, 0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule